// File: doc/BRIEF.md
# Sprite attribute table byte port

This block gives a processor byte-wide access to a 544-byte sprite attribute table kept inside the block. The table has two regions. The main region holds 512 bytes as 256 words. The upper region holds 32 single bytes. A 9-bit reload value is loaded in two parts, and each load also sets the 10-bit working byte address to that value with bit 0 cleared. Every data write and every data read then moves the working address on by one byte.

In the main region a write to an even byte only lands in a shared low-byte holding latch. The following write to an odd byte stores a whole word, made of the new byte and the latch. In the upper region each write is stored at once. A start-of-vertical-blank pulse puts the reload value back into the working address, unless forced blank is active. The high address byte also carries a priority-rotation flag. The block stores this flag and drives it out, and does nothing else with it.

Top module: `sat_port`

## Requirements
- R1: After reset, `byte_addr` is 0x000, `rot_flag` is 0 and `rdata` is 0x00.
- R2: A pulse on `load_lo` sets reload bits 7:0 to `wdata`. A pulse on `load_hi` sets reload bit 8 to `wdata` bit 0. On the next cycle after either pulse, `byte_addr` equals the full 9-bit reload value shifted left by one, so bit 0 is 0.
- R3: A pulse on `load_hi` sets `rot_flag` to `wdata` bit 7. Only `load_hi` and reset change the flag.
- R4: A data write at an even byte address below 0x200 changes no table byte. It only sets the low-byte holding latch to `wdata`.
- R5: A data write at an odd byte address A below 0x200 stores the latch at byte A-1 and `wdata` at byte A, both in the same cycle.
- R6: A data write at byte address 0x200 or above stores `wdata` at once at upper byte (A mod 32). Addresses 0x220 to 0x3FF therefore reach the same 32 bytes as 0x200 to 0x21F.
- R7: Each performed data write or data read adds one to `byte_addr`, and 0x3FF steps to 0x000.
- R8: A data read drives the stored byte at the working address onto `rdata` one cycle after the read strobe. `rdata` holds until the next read. A read never changes the low-byte latch. For example, from address 0 the sequence write 01, write 02, read, write 03 leaves the bytes 01 02 01 03.
- R9: A `vblank_start` pulse while `force_blank` is 0 sets `byte_addr` to the reload value with bit 0 cleared. While `force_blank` is 1 the pulse has no effect.
- R10: When strobes arrive in the same cycle, only one takes effect. The order, highest first, is `load_lo`, `load_hi`, an accepted vertical-blank reload, `wr_en`, then `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_lo | input | 1 | Load reload bits 7:0 from `wdata` |
| load_hi | input | 1 | Load reload bit 8 and the rotation flag from `wdata` |
| wr_en | input | 1 | Data byte write at the working address |
| rd_en | input | 1 | Data byte read at the working address |
| wdata | input | 8 | Write data for loads and data writes |
| vblank_start | input | 1 | Start-of-vertical-blank pulse |
| force_blank | input | 1 | Forced blank active; blocks the vertical-blank reload |
| rdata | output | 8 | Byte returned by the last read |
| byte_addr | output | 10 | Current working byte address |
| rot_flag | output | 1 | Stored priority-rotation flag |

## Verification
The assertions check on every cycle the rules that follow locally from a single strobe:
- a load leaves an even address;
- a write or read steps the address by one;
- an accepted vertical-blank pulse restores the reload value, and a blocked one leaves the address alone;
- an even main-region write never reaches the table;
- an upper-region write always does;
- the latch holds unless a write occurs.

Only the bench's scenarios can show that the bytes stored through the latch are the right ones:
- the word pairing;
- the read that leaves the latch untouched;
- the upper-region mirror;
- the wrap at 0x3FF;
- priority among strobes that collide.

For these the bench compares read-back data against a behavioural model of the table.

// File: rtl/sat_pkg.sv
package sat_pkg;

   typedef enum logic [2:0] {
      OP_IDLE      = 3'd0,
      OP_LOAD_LO   = 3'd1,
      OP_LOAD_HI   = 3'd2,
      OP_VB_RELOAD = 3'd3,
      OP_WRITE     = 3'd4,
      OP_READ      = 3'd5
   } sat_op_e;

   function automatic logic op_steps_addr(input sat_op_e op);
      return (op == OP_WRITE) || (op == OP_READ);
   endfunction

endpackage

// File: rtl/sat_op_decode.sv
module sat_op_decode
   import sat_pkg::*;
(
   input  logic    load_lo,
   input  logic    load_hi,
   input  logic    vblank_start,
   input  logic    force_blank,
   input  logic    wr_en,
   input  logic    rd_en,
   output sat_op_e op
);

   logic vb_accept;
   assign vb_accept = vblank_start && !force_blank;

   // Fixed priority: address loads, then blank reload, then data traffic
   always_comb begin
      if (load_lo)        op = OP_LOAD_LO;
      else if (load_hi)   op = OP_LOAD_HI;
      else if (vb_accept) op = OP_VB_RELOAD;
      else if (wr_en)     op = OP_WRITE;
      else if (rd_en)     op = OP_READ;
      else                op = OP_IDLE;
   end

endmodule

// File: rtl/sat_addr_ctrl.sv
module sat_addr_ctrl
   import sat_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int RELOAD_W = 9,
   parameter int ADDR_W   = 10,
   parameter int ROT_BIT  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sat_op_e           op,
   input  logic [DATA_W-1:0] wdata,
   output logic [ADDR_W-1:0] byte_addr,
   output logic              rot_flag
);

   localparam int HI_W = RELOAD_W - DATA_W;

   if (HI_W < 1) begin : g_bad_reload
      $error("sat_addr_ctrl: RELOAD_W must exceed DATA_W");
   end
   if (RELOAD_W + 1 != ADDR_W) begin : g_bad_addr
      $error("sat_addr_ctrl: ADDR_W must be RELOAD_W + 1");
   end
   if (ROT_BIT >= DATA_W) begin : g_bad_rot
      $error("sat_addr_ctrl: ROT_BIT outside data byte");
   end

   logic [RELOAD_W-1:0] reload_q;
   logic [RELOAD_W-1:0] reload_nxt;
   logic [ADDR_W-1:0]   addr_nxt;
   logic                flag_nxt;

   always_comb begin
      reload_nxt = reload_q;
      flag_nxt   = rot_flag;
      addr_nxt   = byte_addr;
      unique case (op)
         OP_LOAD_LO: begin
            reload_nxt = {reload_q[RELOAD_W-1:DATA_W], wdata};
            addr_nxt   = {reload_nxt, 1'b0};
         end
         OP_LOAD_HI: begin
            reload_nxt = {wdata[HI_W-1:0], reload_q[DATA_W-1:0]};
            flag_nxt   = wdata[ROT_BIT];
            addr_nxt   = {reload_nxt, 1'b0};
         end
         OP_VB_RELOAD: addr_nxt = {reload_q, 1'b0};
         OP_WRITE, OP_READ: addr_nxt = byte_addr + 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q  <= '0;
         byte_addr <= '0;
         rot_flag  <= 1'b0;
      end else begin
         reload_q  <= reload_nxt;
         byte_addr <= addr_nxt;
         rot_flag  <= flag_nxt;
      end
   end

   // R2
   load_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_LOAD_LO || op == OP_LOAD_HI) |=> (byte_addr[0] == 1'b0));

   // R7
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_steps_addr(op) |=> (byte_addr == ADDR_W'($past(byte_addr) + 1'b1)));

   // R9
   vb_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_VB_RELOAD) |=> (byte_addr == {reload_q, 1'b0}));

   // R3
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op != OP_LOAD_HI) |=> $stable(rot_flag));

endmodule

// File: rtl/sat_write_stage.sv
module sat_write_stage
   import sat_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 10,
   parameter int LO_BYTES = 512,
   parameter int HI_BYTES = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  sat_op_e               op,
   input  logic [ADDR_W-1:0]     byte_addr,
   input  logic [DATA_W-1:0]     wdata,
   output logic                  lo_we,
   output logic [$clog2(LO_BYTES/2)-1:0] lo_idx,
   output logic [2*DATA_W-1:0]   lo_word,
   output logic                  hi_we,
   output logic [$clog2(HI_BYTES)-1:0]   hi_idx,
   output logic [DATA_W-1:0]     hi_data
);

   localparam int LO_IDX_W = $clog2(LO_BYTES / 2);
   localparam int HI_IDX_W = $clog2(HI_BYTES);

   if ((1 << (LO_IDX_W + 1)) != LO_BYTES) begin : g_bad_lo
      $error("sat_write_stage: LO_BYTES must be a power of two");
   end
   if ((1 << HI_IDX_W) != HI_BYTES) begin : g_bad_hi
      $error("sat_write_stage: HI_BYTES must be a power of two");
   end
   if (LO_BYTES + HI_BYTES > (1 << ADDR_W)) begin : g_bad_span
      $error("sat_write_stage: table exceeds address space");
   end

   logic [DATA_W-1:0] lsb_latch;
   logic              in_low;
   logic              is_write;

   assign in_low   = byte_addr < ADDR_W'(LO_BYTES);
   assign is_write = (op == OP_WRITE);

   assign lo_we   = is_write && in_low && byte_addr[0];
   assign lo_idx  = byte_addr[LO_IDX_W:1];
   assign lo_word = {wdata, lsb_latch};
   assign hi_we   = is_write && !in_low;
   assign hi_idx  = byte_addr[HI_IDX_W-1:0];
   assign hi_data = wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lsb_latch <= '0;
      end else if (is_write && in_low && !byte_addr[0]) begin
         lsb_latch <= wdata;
      end
   end

   // R8
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !is_write |=> $stable(lsb_latch));

endmodule

// File: rtl/sat_store.sv
module sat_store #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 10,
   parameter int LO_BYTES = 512,
   parameter int HI_BYTES = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  lo_we,
   input  logic [$clog2(LO_BYTES/2)-1:0] lo_idx,
   input  logic [2*DATA_W-1:0]   lo_word,
   input  logic                  hi_we,
   input  logic [$clog2(HI_BYTES)-1:0]   hi_idx,
   input  logic [DATA_W-1:0]     hi_data,
   input  logic                  rd_en,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic [DATA_W-1:0]     rdata
);

   localparam int LO_WORDS = LO_BYTES / 2;
   localparam int LO_IDX_W = $clog2(LO_WORDS);
   localparam int HI_IDX_W = $clog2(HI_BYTES);
   localparam int LANES    = 2;

   logic [DATA_W-1:0] lane_q [LANES];
   logic [DATA_W-1:0] hi_q;
   logic [DATA_W-1:0] hi_mem [HI_BYTES];
   logic              rd_low;

   // One byte array per lane of the main region; a word write hits both lanes
   for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
      logic [DATA_W-1:0] mem [LO_WORDS];
      always_ff @(posedge clk) begin
         if (lo_we) mem[lo_idx] <= lo_word[lane*DATA_W +: DATA_W];
      end
      assign lane_q[lane] = mem[rd_addr[LO_IDX_W:1]];
   end

   always_ff @(posedge clk) begin
      if (hi_we) hi_mem[hi_idx] <= hi_data;
   end

   assign hi_q   = hi_mem[rd_addr[HI_IDX_W-1:0]];
   assign rd_low = rd_addr < ADDR_W'(LO_BYTES);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_en) begin
         rdata <= rd_low ? lane_q[rd_addr[0]] : hi_q;
      end
   end

endmodule

// File: rtl/sat_port.sv
module sat_port
   import sat_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int RELOAD_W = 9,
   parameter int ADDR_W   = 10,
   parameter int LO_BYTES = 512,
   parameter int HI_BYTES = 32,
   parameter int ROT_BIT  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_lo,
   input  logic              load_hi,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              vblank_start,
   input  logic              force_blank,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] byte_addr,
   output logic              rot_flag
);

   localparam int LO_IDX_W = $clog2(LO_BYTES / 2);
   localparam int HI_IDX_W = $clog2(HI_BYTES);

   sat_op_e               op;
   logic                  lo_we;
   logic [LO_IDX_W-1:0]   lo_idx;
   logic [2*DATA_W-1:0]   lo_word;
   logic                  hi_we;
   logic [HI_IDX_W-1:0]   hi_idx;
   logic [DATA_W-1:0]     hi_data;

   sat_op_decode u_decode (
      .load_lo      (load_lo),
      .load_hi      (load_hi),
      .vblank_start (vblank_start),
      .force_blank  (force_blank),
      .wr_en        (wr_en),
      .rd_en        (rd_en),
      .op           (op)
   );

   sat_addr_ctrl #(
      .DATA_W   (DATA_W),
      .RELOAD_W (RELOAD_W),
      .ADDR_W   (ADDR_W),
      .ROT_BIT  (ROT_BIT)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .wdata     (wdata),
      .byte_addr (byte_addr),
      .rot_flag  (rot_flag)
   );

   sat_write_stage #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .LO_BYTES (LO_BYTES),
      .HI_BYTES (HI_BYTES)
   ) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .byte_addr (byte_addr),
      .wdata     (wdata),
      .lo_we     (lo_we),
      .lo_idx    (lo_idx),
      .lo_word   (lo_word),
      .hi_we     (hi_we),
      .hi_idx    (hi_idx),
      .hi_data   (hi_data)
   );

   sat_store #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .LO_BYTES (LO_BYTES),
      .HI_BYTES (HI_BYTES)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .lo_we   (lo_we),
      .lo_idx  (lo_idx),
      .lo_word (lo_word),
      .hi_we   (hi_we),
      .hi_idx  (hi_idx),
      .hi_data (hi_data),
      .rd_en   (op == OP_READ),
      .rd_addr (byte_addr),
      .rdata   (rdata)
   );

   // R4
   even_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_WRITE && !byte_addr[0] && byte_addr < ADDR_W'(LO_BYTES))
         |-> (!lo_we && !hi_we));

   // R6
   upper_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_WRITE && byte_addr >= ADDR_W'(LO_BYTES)) |-> hi_we);

   // R9
   blank_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vblank_start && force_blank && !load_lo && !load_hi && !wr_en && !rd_en)
         |=> $stable(byte_addr));

endmodule

// File: tb/sat_port_tb.sv
`timescale 1ns/1ps
module sat_port_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_lo = 0, load_hi = 0, wr_en = 0, rd_en = 0;
   logic       vblank_start = 0, force_blank = 0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [9:0] byte_addr;
   logic       rot_flag;

   always #2 clk = ~clk;

   sat_port u_dut (
      .clk (clk), .rst_n (rst_n),
      .load_lo (load_lo), .load_hi (load_hi),
      .wr_en (wr_en), .rd_en (rd_en), .wdata (wdata),
      .vblank_start (vblank_start), .force_blank (force_blank),
      .rdata (rdata), .byte_addr (byte_addr), .rot_flag (rot_flag)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   // behavioural model
   int m_reload, m_addr, m_flag, m_latch, m_rd;
   bit m_rd_known;
   int m_lo [512];
   bit k_lo [512];
   int m_hi [32];
   bit k_hi [32];

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic model_read();
      if (m_addr >= 'h200) begin
         m_rd = m_hi[m_addr & 31]; m_rd_known = k_hi[m_addr & 31];
      end else begin
         m_rd = m_lo[m_addr]; m_rd_known = k_lo[m_addr];
      end
   endtask

   task automatic model_write(input int d);
      if (m_addr >= 'h200) begin
         m_hi[m_addr & 31] = d; k_hi[m_addr & 31] = 1;
      end else if ((m_addr & 1) == 0) begin
         m_latch = d;
      end else begin
         m_lo[m_addr - 1] = m_latch; k_lo[m_addr - 1] = 1;
         m_lo[m_addr] = d;           k_lo[m_addr] = 1;
      end
   endtask

   task automatic step(input bit llo, input bit lhi, input bit lw, input bit lr,
                       input bit lvb, input bit lfb, input logic [7:0] d, input string tag);
      @(negedge clk);
      load_lo = llo; load_hi = lhi; wr_en = lw; rd_en = lr;
      vblank_start = lvb; force_blank = lfb; wdata = d;
      @(posedge clk);
      if (llo) begin
         m_reload = (m_reload & 'h100) | d; m_addr = m_reload * 2;
      end else if (lhi) begin
         m_reload = (m_reload & 'hff) | ((d & 1) << 8); m_flag = d[7];
         m_addr = m_reload * 2;
      end else if (lvb && !lfb) begin
         m_addr = m_reload * 2;
      end else if (lw) begin
         model_write(d); m_addr = (m_addr + 1) & 'h3ff;
      end else if (lr) begin
         model_read(); m_addr = (m_addr + 1) & 'h3ff;
      end
      #1;
      check(tag, "byte_addr", byte_addr, m_addr);
      check(tag, "rot_flag", rot_flag, m_flag);
      if (m_rd_known) check(tag, "rdata", rdata, m_rd);
   endtask

   task automatic idle(input string tag);
      step(0, 0, 0, 0, 0, 0, 8'h00, tag);
   endtask

   task automatic set_addr(input int rl, input bit flag, input string tag);
      step(1, 0, 0, 0, 0, 0, 8'(rl & 'hff), tag);
      step(0, 1, 0, 0, 0, 0, {flag, 6'd0, 1'(rl >> 8)}, tag);
   endtask

   task automatic wr(input logic [7:0] d, input string tag);
      step(0, 0, 1, 0, 0, 0, d, tag);
   endtask

   task automatic rd(input string tag);
      step(0, 0, 0, 1, 0, 0, 8'h00, tag);
      idle(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      m_reload = 0; m_addr = 0; m_flag = 0; m_latch = 0; m_rd = 0; m_rd_known = 1;
      for (int i = 0; i < 512; i++) k_lo[i] = 0;
      for (int i = 0; i < 32; i++) k_hi[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      // R1 reset values
      #0.5;
      check("R1", "byte_addr", byte_addr, 0);
      check("R1", "rot_flag", rot_flag, 0);
      check("R1", "rdata", rdata, 0);

      // R2 reload in two halves, address follows with bit 0 clear
      step(1, 0, 0, 0, 0, 0, 8'h04, "R2");
      step(0, 1, 0, 0, 0, 0, 8'h01, "R2");
      step(0, 1, 0, 0, 0, 0, 8'h00, "R2");
      // R3 rotation flag from bit 7
      step(0, 1, 0, 0, 0, 0, 8'h80, "R3");
      step(1, 0, 0, 0, 0, 0, 8'h00, "R3");
      step(0, 1, 0, 0, 0, 0, 8'h01, "R3");

      // R8 / R5 write 1, write 2, read, write 3 from 0 -> 01 02 01 03
      set_addr(0, 0, "R8");
      wr(8'h01, "R8"); wr(8'h02, "R8"); rd("R8"); wr(8'h03, "R8");
      set_addr(0, 0, "R5");
      for (int i = 0; i < 4; i++) rd("R5");

      // R4 even write alone leaves the table unchanged
      set_addr(8, 0, "R4");
      wr(8'hAA, "R4"); wr(8'hBB, "R4");
      set_addr(8, 0, "R4");
      wr(8'h55, "R4");
      set_addr(8, 0, "R4");
      rd("R4"); rd("R4");

      // R6 upper region immediate and mirrored
      set_addr('h100, 0, "R6");
      wr(8'h11, "R6"); rd("R6");
      set_addr('h110, 0, "R6");
      rd("R6");
      set_addr('h10F, 0, "R6");
      wr(8'h77, "R6"); wr(8'h66, "R6");
      set_addr('h11F, 0, "R6");
      rd("R6"); rd("R6");

      // R7 wrap 0x3FF -> 0x000
      set_addr('h1FF, 0, "R7");
      wr(8'hC1, "R7"); wr(8'hC2, "R7");
      rd("R7");

      // R9 vblank reload, blocked by forced blank
      set_addr('h040, 0, "R9");
      wr(8'h01, "R9"); wr(8'h02, "R9"); wr(8'h03, "R9");
      step(0, 0, 0, 0, 1, 1, 8'h00, "R9");
      step(0, 0, 0, 0, 1, 0, 8'h00, "R9");

      // R10 collisions
      step(1, 1, 1, 1, 1, 0, 8'h22, "R10");
      step(0, 1, 1, 1, 1, 0, 8'h81, "R10");
      wr(8'h09, "R10");
      step(0, 0, 1, 1, 1, 0, 8'h33, "R10");
      step(0, 0, 1, 1, 1, 1, 8'h44, "R10");
      step(0, 0, 0, 1, 1, 1, 8'h00, "R10");

      // mixed traffic against the model
      for (int i = 0; i < 3000; i++) begin
         int pick;
         pick = $urandom_range(0, 19);
         case (pick)
            0:       step(1, 0, 0, 0, 0, 0, 8'($urandom), "R2");
            1:       step(0, 1, 0, 0, 0, 0, 8'($urandom), "R3");
            2:       step(0, 0, 0, 0, 1, 1'($urandom), 8'h00, "R9");
            3:       step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                          1'($urandom), 1'($urandom), 8'($urandom), "R10");
            4, 5, 6, 7, 8, 9, 10, 11: step(0, 0, 1, 0, 0, 0, 8'($urandom), "R5");
            default: step(0, 0, 0, 1, 0, 0, 8'h00, "R8");
         endcase
      end
      idle("R7");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule